// File: doc/BRIEF.md
# Adaptive Transmit FIFO Trigger Level

This block keeps the threshold at which a transmit FIFO starts handing buffered data to the transmitter. The threshold is counted in units of 64 bytes and starts at its lowest working value. A controller raises it after an underrun, or lowers it to reach the air sooner with short frames. Each request goes through a fixed update sequence. Global interrupts are held off for the whole sequence. When it ends, a one-cycle completion pulse reports whether the threshold moved or whether a limit refused the change.

The two directions take steps of different sizes. An increase closes half of the remaining gap up to the configured maximum, using integer division. A decrease lowers the threshold by exactly one and never goes below the configured minimum. All pins are plain control and status signals. There is no data stream, so there is no valid/ready handshake. A request that arrives while an update is in progress is dropped, not queued.

Top module: `txtrig_ctrl`

## Requirements
- R1: After reset, `level` equals the parameter `RESET_LEVEL` (default 1, meaning 64 bytes), `hold` and `done` are 0, and `irq_en_out` follows `irq_en_in`.
- R2: A decrease with `level - 1 >= min_level` stores `level - 1` and reports `limit_err = 0` at completion.
- R3: A decrease with `level == 0` or `level - 1 < min_level` leaves `level` unchanged and reports `limit_err = 1` at completion.
- R4: An increase with `step = floor((max_level - level) / 2) > 0` stores `level + step` and reports `limit_err = 0`. If `max_level <= level`, the step is 0.
- R5: An increase whose step is 0 leaves `level` unchanged and reports `limit_err = 1`.
- R6: When `inc_req` and `dec_req` are both high in the accepting cycle, the increase is carried out and the decrease is discarded.
- R7: A request sampled high at a clock edge while idle raises `hold` after that edge. `hold` stays high for exactly two cycles. `level` and a one-cycle `done` change at the edge that lowers `hold`, and `level` changes at no other time.
- R8: `irq_en_out` is 0 while `hold` is high. At every other time it equals `irq_en_in`, whether or not the update succeeded.
- R9: Requests sampled while `hold` is high have no effect on the result or on the duration of the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| inc_req | input | 1 | Request to raise the threshold |
| dec_req | input | 1 | Request to lower the threshold |
| min_level | input | LVL_W | Lowest threshold allowed for a decrease |
| max_level | input | LVL_W | Ceiling that an increase approaches |
| irq_en_in | input | 1 | Global interrupt enable as configured |
| level | output | LVL_W | Current threshold in 64-byte units |
| done | output | 1 | One-cycle pulse at the end of an update |
| limit_err | output | 1 | With `done`: 1 if a limit refused the change |
| hold | output | 1 | High while the update holds interrupts off |
| irq_en_out | output | 1 | Global interrupt enable after suppression |

## Verification
The hardest state to reach from the ports is a threshold resting exactly at the minimum or exactly one below the maximum. Reset always returns the threshold to 1, so these points can only be reached by a chain of requests. The bench sweeps a grid of minimum and maximum settings. For each one it walks the threshold down until the floor refuses, then climbs by halving steps until the ceiling refuses, then descends again. This passes through every limit boundary. During some updates, extra requests are injected while the block is busy, and some requests raise both directions at once.

// File: rtl/txtrig_pkg.sv
package txtrig_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_MASK = 2'd1,
    ST_UPD  = 2'd2
  } txtrig_state_t;

  typedef enum logic {
    OP_DEC = 1'b0,
    OP_INC = 1'b1
  } txtrig_op_t;
endpackage

// File: rtl/txtrig_calc.sv
module txtrig_calc #(
  parameter int LVL_W = 6
) (
  input  logic [LVL_W-1:0]   cur,
  input  logic [LVL_W-1:0]   lo,
  input  logic [LVL_W-1:0]   hi,
  input  txtrig_pkg::txtrig_op_t op,
  output logic [LVL_W-1:0]   nxt,
  output logic               refuse
);
  localparam int EXT_W = LVL_W + 1;

  logic [EXT_W-1:0] gap;
  logic [EXT_W-1:0] step;
  logic [EXT_W-1:0] raised;

  always_comb begin
    gap    = (hi > cur) ? ({1'b0, hi} - {1'b0, cur}) : '0;
    step   = gap >> 1;
    raised = {1'b0, cur} + step;
    nxt    = cur;
    refuse = 1'b0;
    if (op == txtrig_pkg::OP_INC) begin
      if (step == '0) refuse = 1'b1;
      else            nxt    = raised[LVL_W-1:0];
    end else begin
      if (cur == '0 || (cur - 1'b1) < lo) refuse = 1'b1;
      else                                nxt    = cur - 1'b1;
    end
  end
endmodule

// File: rtl/txtrig_seq.sv
module txtrig_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic inc_req,
  input  logic dec_req,
  output txtrig_pkg::txtrig_op_t op_q,
  output logic hold,
  output logic commit
);
  import txtrig_pkg::*;

  txtrig_state_t st_q, st_d;

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE: if (inc_req || dec_req) st_d = ST_MASK;
      ST_MASK: st_d = ST_UPD;
      ST_UPD:  st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
      op_q <= OP_DEC;
    end else begin
      st_q <= st_d;
      if (st_q == ST_IDLE && (inc_req || dec_req))
        op_q <= inc_req ? OP_INC : OP_DEC;
    end
  end

  assign hold   = (st_q != ST_IDLE);
  assign commit = (st_q == ST_UPD);

  a_r7_hold_two: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold) |=> hold);
  a_r7_hold_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && $past(hold)) |=> !hold);
  a_r9_op_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && $past(hold)) |-> $stable(op_q));
endmodule

// File: rtl/txtrig_ctrl.sv
module txtrig_ctrl #(
  parameter int LVL_W       = 6,
  parameter int RESET_LEVEL = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc_req,
  input  logic             dec_req,
  input  logic [LVL_W-1:0] min_level,
  input  logic [LVL_W-1:0] max_level,
  input  logic             irq_en_in,
  output logic [LVL_W-1:0] level,
  output logic             done,
  output logic             limit_err,
  output logic             hold,
  output logic             irq_en_out
);
  import txtrig_pkg::*;

  localparam logic [LVL_W-1:0] LVL_RST = LVL_W'(RESET_LEVEL);

  txtrig_op_t       op_q;
  logic             commit;
  logic [LVL_W-1:0] lvl_q;
  logic [LVL_W-1:0] lvl_nxt;
  logic             refuse;

  txtrig_seq u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .inc_req (inc_req),
    .dec_req (dec_req),
    .op_q    (op_q),
    .hold    (hold),
    .commit  (commit)
  );

  txtrig_calc #(.LVL_W(LVL_W)) u_calc (
    .cur    (lvl_q),
    .lo     (min_level),
    .hi     (max_level),
    .op     (op_q),
    .nxt    (lvl_nxt),
    .refuse (refuse)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q     <= LVL_RST;
      done      <= 1'b0;
      limit_err <= 1'b0;
    end else begin
      done <= commit;
      if (commit) begin
        limit_err <= refuse;
        lvl_q     <= lvl_nxt;
      end
    end
  end

  assign level      = lvl_q;
  assign irq_en_out = irq_en_in & ~hold;

  a_r7_level_moves_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(lvl_q) |-> done);
  a_r7_done_after_hold: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(hold) && !hold));
  a_r8_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
    hold |-> !irq_en_out);
  a_r3_refused_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (done && limit_err) |-> $stable(lvl_q));
  a_r4_inc_grows: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !limit_err && op_q == OP_INC) |-> (lvl_q > $past(lvl_q)));
endmodule

// File: tb/test_txtrig_ctrl.sv
module test_txtrig_ctrl;
  localparam int W = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic inc_req = 1'b0, dec_req = 1'b0;
  logic [W-1:0] min_level = '0, max_level = '0;
  logic irq_en_in = 1'b0;
  logic [W-1:0] level;
  logic done, limit_err, hold, irq_en_out;

  int errors = 0;
  int checks = 0;
  int model_lv;

  always #2.5 clk = ~clk;

  txtrig_ctrl #(.LVL_W(W), .RESET_LEVEL(1)) i_txtrig_ctrl (
    .clk(clk), .rst_n(rst_n), .inc_req(inc_req), .dec_req(dec_req),
    .min_level(min_level), .max_level(max_level), .irq_en_in(irq_en_in),
    .level(level), .done(done), .limit_err(limit_err), .hold(hold),
    .irq_en_out(irq_en_out)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    model_lv = 1;
    @(negedge clk);
    chk(level == 1, "R1 reset level", level, 1);
    chk(!hold && !done, "R1 reset hold/done", {hold, done}, 0);
    chk(irq_en_out == irq_en_in, "R1 irq follow", irq_en_out, irq_en_in);
  endtask

  task automatic run_op(input bit inc, input bit dec, input bit noise);
    int step;
    int exp_lv;
    bit exp_err;
    exp_lv = model_lv;
    exp_err = 1'b0;
    if (inc) begin
      step = (int'(max_level) > model_lv) ? (int'(max_level) - model_lv) / 2 : 0;
      if (step == 0) exp_err = 1'b1;
      else exp_lv = model_lv + step;
    end else begin
      if (model_lv == 0 || model_lv - 1 < int'(min_level)) exp_err = 1'b1;
      else exp_lv = model_lv - 1;
    end
    @(negedge clk);
    inc_req = inc;
    dec_req = dec;
    @(negedge clk);
    inc_req = 1'b0;
    dec_req = noise;
    chk(hold == 1'b1, "R7 hold first cycle", hold, 1);
    chk(irq_en_out == 1'b0, "R8 irq masked", irq_en_out, 0);
    @(negedge clk);
    inc_req = noise;
    dec_req = 1'b0;
    chk(hold == 1'b1 && done == 1'b0, "R7 hold second cycle", {hold, done}, 2);
    @(negedge clk);
    inc_req = 1'b0;
    chk(hold == 1'b0 && done == 1'b1, "R7 completion", {hold, done}, 1);
    chk(irq_en_out == irq_en_in, "R8 irq restored", irq_en_out, irq_en_in);
    if (inc && dec) begin
      chk(int'(level) == exp_lv, "R6 both -> increase", level, exp_lv);
    end else if (noise) begin
      chk(int'(level) == exp_lv, "R9 busy request ignored", level, exp_lv);
    end else if (inc) begin
      chk(int'(level) == exp_lv, exp_err ? "R5 inc limit level" : "R4 inc level", level, exp_lv);
    end else begin
      chk(int'(level) == exp_lv, exp_err ? "R3 dec limit level" : "R2 dec level", level, exp_lv);
    end
    chk(limit_err == exp_err, inc ? "R4/R5 inc status" : "R2/R3 dec status", limit_err, exp_err);
    @(negedge clk);
    chk(done == 1'b0 && int'(level) == exp_lv, "R7 done one cycle", {done, level}, exp_lv);
    model_lv = exp_lv;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    int cfg;
    cfg = 0;
    for (int mn = 0; mn < 4; mn++) begin
      for (int k = 0; k < 5; k++) begin
        int mx;
        case (k)
          0: mx = mn;
          1: mx = mn + 1;
          2: mx = mn + 2;
          3: mx = mn + 7;
          default: mx = (1 << W) - 1;
        endcase
        min_level = W'(mn);
        max_level = W'(mx);
        irq_en_in = cfg[0];
        do_reset();
        for (int d = 0; d < 3; d++) run_op(1'b0, 1'b1, 1'b0);
        for (int u = 0; u < 8; u++) run_op(1'b1, (u == 1), (u == 2));
        irq_en_in = ~irq_en_in;
        for (int d = 0; d < 3; d++) run_op(1'b0, 1'b1, (d == 0));
        cfg++;
      end
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule